// File: doc/BRIEF.md
# Debugger Access Protection Gate

This block sits between an external debug port and the system bus and decides, for every debugger bus request, whether the request may proceed. The decision depends on two protection levels, captured once per reset. A full-protect level shuts out the debugger entirely. A secure-only level lets the debugger reach non-secure code, memory and peripherals only. The decision also depends on the permissions of the region being accessed. A region that may be executed can always be read, so that a debugger can show the code that is running.

The block also follows the debugger's power-up request. While that request is held, the device is in debug interface mode; otherwise it is in normal mode. A power-up request that arrives while the system is off wakes the system with a one-cycle pulse. It also sets a sticky reason flag that software clears with a write-one-to-clear strobe. A pin reset leaves that flag alone; only a power-on reset clears it.

Top module: `dbg_access_gate`

## Requirements
- R1: With the captured full-protect bit set, every request is answered with rsp_grant = 0, whatever the secure-only bit is.
- R2: With full-protect clear and secure-only set, a request with req_secure = 1 is denied and a request with req_secure = 0 may be granted.
- R3: With both captured protection bits clear, requests with req_secure = 0 and with req_secure = 1 may both be granted.
- R4: A read (req_write = 0) passes the region check when region_rd = 1 or region_ex = 1.
- R5: A write (req_write = 1) passes the region check only when region_wr = 1; region_rd and region_ex do not matter for writes.
- R6: rsp_valid is high in the cycle after a cycle with req_valid = 1, and only then. rsp_grant carries the decision in that cycle and is 0 whenever rsp_valid is 0.
- R7: dbg_mode goes high one clock after pwrup_req is sampled high and goes low one clock after pwrup_req is sampled low.
- R8: A request sampled while dbg_mode = 0 is denied, whatever the protection bits and permissions are.
- R9: When pwrup_req is sampled high while dbg_mode = 0 and sys_off = 1, wake_pulse is high for exactly one cycle and wake_flag becomes 1 in the same cycle. A rise of pwrup_req with sys_off = 0 gives neither.
- R10: wake_flag stays 1 until wake_flag_clr is sampled high or por_n is asserted. An assertion of rst_n alone leaves it unchanged.
- R11: The protection inputs are captured at the first clock edge after reset is released and are held until the next reset, so later changes to them have no effect. A request sampled at that first edge is treated as fully protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| rst_n | input | 1 | Pin reset, active low, asynchronous; keeps wake_flag |
| prot_full_in | input | 1 | Full-protect bit from non-volatile configuration |
| prot_secure_in | input | 1 | Secure-only-protect bit from non-volatile configuration |
| pwrup_req | input | 1 | Debugger power-up request level |
| sys_off | input | 1 | System is in the off state |
| wake_flag_clr | input | 1 | Write-one-to-clear strobe for wake_flag |
| req_valid | input | 1 | Debugger request present this cycle |
| req_secure | input | 1 | Request carries the secure attribute |
| req_write | input | 1 | 1 = write, 0 = read |
| region_rd | input | 1 | Target region grants read permission |
| region_wr | input | 1 | Target region grants write permission |
| region_ex | input | 1 | Target region grants execute permission |
| rsp_valid | output | 1 | Response present (one clock after the request) |
| rsp_grant | output | 1 | 1 = request granted, 0 = denied |
| dbg_mode | output | 1 | Debug interface mode flag |
| wake_pulse | output | 1 | One-cycle wake request toward the power controller |
| wake_flag | output | 1 | Sticky debug-wake reason flag |

## Verification
The assertions assume that the request descriptor fields are driven only as qualifiers of req_valid. They also assume that both resets are applied and released away from the clock edge, so that the captured protection state reflects the inputs present at the first edge after release. The stimulus drives every input at the falling edge and issues requests as single-cycle pulses, so at most one response is pending. Protection inputs are changed only while a reset is held, except in one deliberate case that checks later changes are ignored. The power-up request is toggled only with both resets released, so wake detection sees clean rising edges.

// File: rtl/dag_pkg.sv
package dag_pkg;

  typedef struct packed {
    logic full;
    logic sonly;
  } dag_prot_t;

  typedef struct packed {
    logic valid;
    logic secure;
    logic write;
    logic rd;
    logic wr;
    logic ex;
  } dag_req_t;

  localparam dag_prot_t DAG_PROT_SAFE = '{full: 1'b1, sonly: 1'b1};

  // Protection level check: full blocks all, secure-only blocks secure accesses
  function automatic logic dag_level_ok(input dag_prot_t p, input logic secure);
    logic ok;
    ok = 1'b1;
    if (p.full) ok = 1'b0;
    else if (p.sonly && secure) ok = 1'b0;
    return ok;
  endfunction

  // Region permission check: execute implies readable, writes need write permission
  function automatic logic dag_region_ok(input logic write, input logic rd,
                                         input logic wr, input logic ex);
    logic ok;
    if (write) ok = wr;
    else       ok = rd | ex;
    return ok;
  endfunction

endpackage

// File: rtl/dag_prot_latch.sv
module dag_prot_latch
  import dag_pkg::*;
#(
  parameter dag_prot_t RESET_PROT = DAG_PROT_SAFE
) (
  input  logic      clk,
  input  logic      rst_n,
  input  dag_prot_t prot_in,
  output dag_prot_t prot_q,
  output logic      locked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= RESET_PROT;
      locked <= 1'b0;
    end else if (!locked) begin
      prot_q <= prot_in;
      locked <= 1'b1;
    end
  end

  // R11
  prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(prot_q));

  // R11
  locked_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> locked);

endmodule

// File: rtl/dag_mode_track.sv
module dag_mode_track (
  input  logic clk,
  input  logic por_n,
  input  logic sys_rst_n,
  input  logic pwrup_req,
  input  logic sys_off,
  input  logic flag_clr,
  output logic dbg_mode,
  output logic wake_pulse,
  output logic wake_flag,
  output logic wake_evt
);

  assign wake_evt = sys_rst_n & pwrup_req & ~dbg_mode & sys_off;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      dbg_mode   <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      dbg_mode   <= pwrup_req;
      wake_pulse <= wake_evt;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         wake_flag <= 1'b0;
    else if (wake_evt)  wake_flag <= 1'b1;
    else if (flag_clr)  wake_flag <= 1'b0;
  end

  // R7
  mode_rise_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    pwrup_req |=> dbg_mode);

  // R7
  mode_fall_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !pwrup_req |=> !dbg_mode);

  // R9
  wake_needs_off_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wake_pulse |-> ($past(sys_off) && $rose(dbg_mode)));

  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wake_pulse |=> !wake_pulse);

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(wake_flag) |-> $past(flag_clr));

endmodule

// File: rtl/dag_decide.sv
module dag_decide
  import dag_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  dag_prot_t prot,
  input  logic      mode,
  input  dag_req_t  req,
  output logic      rsp_valid,
  output logic      rsp_grant,
  output logic      grant_now
);

  logic level_ok;
  logic region_ok;

  assign level_ok  = dag_level_ok(prot, req.secure);
  assign region_ok = dag_region_ok(req.write, req.rd, req.wr, req.ex);
  assign grant_now = req.valid & mode & level_ok & region_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
    end else begin
      rsp_valid <= req.valid;
      rsp_grant <= grant_now;
    end
  end

  // R6
  rsp_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req.valid));

  // R6
  grant_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_grant |-> rsp_valid);

  // R1
  full_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.valid && prot.full) |=> !rsp_grant);

  // R2
  secure_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.valid && prot.sonly && req.secure) |=> !rsp_grant);

  // R5
  write_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.valid && req.write && !req.wr) |=> !rsp_grant);

  // R8
  normal_mode_denies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req.valid && !mode) |=> !rsp_grant);

endmodule

// File: rtl/dbg_access_gate.sv
module dbg_access_gate
  import dag_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  input  logic prot_full_in,
  input  logic prot_secure_in,
  input  logic pwrup_req,
  input  logic sys_off,
  input  logic wake_flag_clr,
  input  logic req_valid,
  input  logic req_secure,
  input  logic req_write,
  input  logic region_rd,
  input  logic region_wr,
  input  logic region_ex,
  output logic rsp_valid,
  output logic rsp_grant,
  output logic dbg_mode,
  output logic wake_pulse,
  output logic wake_flag
);

  logic      sys_rst_n;
  dag_prot_t prot_in;
  dag_prot_t prot_q;
  logic      prot_locked;
  dag_req_t  req;
  logic      grant_now;
  logic      wake_evt;

  assign sys_rst_n = por_n & rst_n;
  assign prot_in   = '{full: prot_full_in, sonly: prot_secure_in};
  assign req       = '{valid: req_valid, secure: req_secure, write: req_write,
                       rd: region_rd, wr: region_wr, ex: region_ex};

  dag_prot_latch u_latch (
    .clk     (clk),
    .rst_n   (sys_rst_n),
    .prot_in (prot_in),
    .prot_q  (prot_q),
    .locked  (prot_locked)
  );

  dag_mode_track u_mode (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst_n  (sys_rst_n),
    .pwrup_req  (pwrup_req),
    .sys_off    (sys_off),
    .flag_clr   (wake_flag_clr),
    .dbg_mode   (dbg_mode),
    .wake_pulse (wake_pulse),
    .wake_flag  (wake_flag),
    .wake_evt   (wake_evt)
  );

  dag_decide u_decide (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .prot      (prot_q),
    .mode      (dbg_mode),
    .req       (req),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .grant_now (grant_now)
  );

  // R11
  early_req_denied_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (req_valid && !prot_locked) |=> !rsp_grant);

  // R9
  wake_sets_flag_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    wake_evt |=> (wake_flag && wake_pulse));

  // R6
  grant_matches_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    grant_now |=> rsp_grant);

endmodule

// File: tb/tb_dbg_access_gate.sv
module tb_dbg_access_gate;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic prot_full_in = 1'b0, prot_secure_in = 1'b0;
  logic pwrup_req = 1'b0, sys_off = 1'b0, wake_flag_clr = 1'b0;
  logic req_valid = 1'b0, req_secure = 1'b0, req_write = 1'b0;
  logic region_rd = 1'b0, region_wr = 1'b0, region_ex = 1'b0;
  logic rsp_valid, rsp_grant, dbg_mode, wake_pulse, wake_flag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string phase = "R6";

  always #10 clk = ~clk;

  dbg_access_gate dut (.*);

  // Behavioural reference model
  bit m_cap, m_full, m_sonly, m_mode, m_wake, m_flag, m_rv, m_rg;

  function automatic bit rule(bit full, bit sonly, bit mode, bit sec,
                              bit wr_op, bit prd, bit pwr, bit pex);
    if (!mode) return 0;
    if (full) return 0;
    if (sonly && sec) return 0;
    if (wr_op) return pwr;
    return (prd || pex);
  endfunction

  always @(posedge clk) begin
    if (!por_n) begin
      m_cap <= 0; m_full <= 1; m_sonly <= 1; m_mode <= 0;
      m_wake <= 0; m_flag <= 0; m_rv <= 0; m_rg <= 0;
    end else if (!rst_n) begin
      m_cap <= 0; m_full <= 1; m_sonly <= 1; m_mode <= 0;
      m_wake <= 0; m_rv <= 0; m_rg <= 0;
      if (wake_flag_clr) m_flag <= 0;
    end else begin
      m_rv <= req_valid;
      m_rg <= req_valid && rule(m_full, m_sonly, m_mode, req_secure, req_write,
                                region_rd, region_wr, region_ex);
      if (!m_cap) begin
        m_full <= prot_full_in; m_sonly <= prot_secure_in; m_cap <= 1;
      end
      m_wake <= pwrup_req && !m_mode && sys_off;
      if (pwrup_req && !m_mode && sys_off) m_flag <= 1;
      else if (wake_flag_clr) m_flag <= 0;
      m_mode <= pwrup_req;
    end
  end

  // Per-cycle comparison, mid high phase
  always @(posedge clk) begin
    #5;
    cycles++;
    checks++;
    if ({rsp_valid, rsp_grant, dbg_mode, wake_pulse, wake_flag} !==
        {m_rv, m_rg, m_mode, m_wake, m_flag}) begin
      fails++;
      $display("FAIL %s cycle %0d: got v/g/m/w/f=%b%b%b%b%b expected %b%b%b%b%b",
               phase, cycles, rsp_valid, rsp_grant, dbg_mode, wake_pulse, wake_flag,
               m_rv, m_rg, m_mode, m_wake, m_flag);
    end
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // One request pulse; returns the registered grant
  task automatic do_req(bit sec, bit w, bit prd, bit pwr, bit pex, output logic g);
    @(negedge clk);
    req_valid = 1; req_secure = sec; req_write = w;
    region_rd = prd; region_wr = pwr; region_ex = pex;
    @(negedge clk);
    req_valid = 0;
    g = rsp_grant;
    check({phase, " rsp_valid"}, rsp_valid, 1'b1);
  endtask

  task automatic sweep(string tag, bit full, bit sonly, bit mode);
    logic g;
    phase = tag;
    for (int k = 0; k < 32; k++) begin
      do_req(k[4], k[3], k[2], k[1], k[0], g);
      check(tag, g, rule(full, sonly, mode, k[4], k[3], k[2], k[1], k[0]));
    end
  endtask

  task automatic pin_reset(bit pf, bit ps);
    @(negedge clk);
    rst_n = 0; prot_full_in = pf; prot_secure_in = ps; pwrup_req = 0;
    idle(2);
    rst_n = 1;
    idle(3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic g;
    phase = "R6";
    idle(3);
    check("R6 reset rsp_valid", rsp_valid, 1'b0);
    check("R7 reset dbg_mode", dbg_mode, 1'b0);
    check("R10 reset wake_flag", wake_flag, 1'b0);
    por_n = 1; rst_n = 1;
    idle(3);

    // R8: not in debug mode, no protection
    sweep("R8", 0, 0, 0);

    // R7: power-up request
    phase = "R7";
    @(negedge clk); pwrup_req = 1;
    @(negedge clk); check("R7 mode rise", dbg_mode, 1'b1);
    check("R9 no wake when on", wake_pulse, 1'b0);

    // R3/R4/R5: unprotected
    sweep("R3", 0, 0, 1);
    do_req(0, 0, 0, 0, 1, g); check("R4 exec-only read", g, 1'b1);
    do_req(0, 1, 0, 0, 1, g); check("R5 exec-only write", g, 1'b0);
    do_req(1, 1, 1, 1, 0, g); check("R5 write with wr", g, 1'b1);

    // R11: mid-session changes ignored
    phase = "R11";
    @(negedge clk); prot_full_in = 1; prot_secure_in = 1;
    do_req(1, 0, 1, 0, 0, g); check("R11 change ignored", g, 1'b1);
    sweep("R11", 0, 0, 1);

    phase = "R7";
    @(negedge clk); pwrup_req = 0;
    @(negedge clk); check("R7 mode fall", dbg_mode, 1'b0);
    do_req(0, 0, 1, 1, 1, g); check("R8 normal mode deny", g, 1'b0);

    // R2: secure-only
    pin_reset(0, 1);
    @(negedge clk); pwrup_req = 1; idle(1);
    sweep("R2", 0, 1, 1);
    do_req(1, 0, 1, 0, 0, g); check("R2 secure deny", g, 1'b0);
    do_req(0, 0, 1, 0, 0, g); check("R2 non-secure grant", g, 1'b1);

    // R1: full protect
    pin_reset(1, 0);
    @(negedge clk); pwrup_req = 1; idle(1);
    sweep("R1", 1, 0, 1);
    pin_reset(1, 1);
    @(negedge clk); pwrup_req = 1; idle(1);
    sweep("R1", 1, 1, 1);

    // R11: request at the capture edge is fully protected
    phase = "R11";
    @(negedge clk);
    rst_n = 0; prot_full_in = 0; prot_secure_in = 0; pwrup_req = 0;
    idle(2);
    rst_n = 1; req_valid = 1; req_secure = 0; req_write = 0; region_rd = 1;
    @(negedge clk); req_valid = 0;
    check("R11 capture edge deny", rsp_grant, 1'b0);
    check("R11 capture edge rsp", rsp_valid, 1'b1);

    // R9: wake from off
    phase = "R9";
    idle(2);
    @(negedge clk); sys_off = 1; pwrup_req = 1;
    @(negedge clk);
    check("R9 wake pulse", wake_pulse, 1'b1);
    check("R9 flag set", wake_flag, 1'b1);
    @(negedge clk);
    check("R9 pulse single", wake_pulse, 1'b0);
    sys_off = 0;

    // R10: pin reset keeps the flag, clear strobe drops it
    phase = "R10";
    pin_reset(0, 0);
    check("R10 pin reset keeps flag", wake_flag, 1'b1);
    @(negedge clk); wake_flag_clr = 1;
    @(negedge clk); wake_flag_clr = 0;
    check("R10 clear strobe", wake_flag, 1'b0);

    // R9: rise with system on gives nothing
    phase = "R9";
    @(negedge clk); pwrup_req = 1;
    @(negedge clk); check("R9 on no pulse", wake_pulse, 1'b0);
    check("R9 on no flag", wake_flag, 1'b0);

    // R10: power-on reset clears the flag
    phase = "R10";
    @(negedge clk); pwrup_req = 0; sys_off = 1;
    @(negedge clk); pwrup_req = 1;
    @(negedge clk); check("R10 flag set again", wake_flag, 1'b1);
    pwrup_req = 0; sys_off = 0;
    @(negedge clk); por_n = 0;
    idle(2);
    check("R10 por clears flag", wake_flag, 1'b0);
    por_n = 1;
    idle(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule